// File: doc/BRIEF.md
# Squib Driver Command Register Bank

This block takes single-byte commands from a serial host link and keeps the control state of a two-channel squib firing stage. Each byte carries a four-bit command code in its upper half and four data bits in its lower half. The bank decodes the code, interprets the data for that command and holds the result. The outputs drive these controls:

- the select of an analog observation multiplexer;
- the enables of two low-side and two high-side firing switches;
- the trip level of the reserve-voltage monitor.

The serial pins (clock, active-low select, data in) are treated as asynchronous. They are brought into the system clock domain through a synchronizer, and the serial clock is oversampled there. A byte is accepted only when the select pin returns high after exactly eight serial clock rising edges. Any other frame is dropped. An accepted byte updates its register in one system clock cycle. The serial link has no back-pressure: the host paces frames, and the serial clock must stay slower than a few system clock periods per level.

Top module: `squib_cmd_bank`

## Requirements
- R1: Command code 0x4 loads the analog select from the data bits. Data 0001, 0010, 0100 and 1000 pick, in that order, the measurement-resistor tap, the auxiliary input, the battery fraction and the reserve fraction. These appear on `amux_sel` as the same one-hot value. Data 0000 gives high impedance, shown as `amux_sel` = 0000.
- R2: Code 0x4 with any data value other than the five in R1 sets `amux_sel` to 0000 (high impedance). `amux_sel` is 0000 after reset.
- R3: Code 0x5 drives the low-side switches with active-low data. D0 = 0 turns on `low_on[0]` (switch 1) and D1 = 0 turns on `low_on[1]` (switch 2). D3 and D2 have no effect.
- R4: Code 0xA drives the high-side switches with active-high data. D0 = 1 turns on `high_on[0]` (switch 1) and D1 = 1 turns on `high_on[1]` (switch 2). D3 and D2 have no effect.
- R5: Code 0x6 sets `vres_trip_hi` to data bit D0, where 0 is the lower trip level and 1 is the higher one. D3 to D1 have no effect.
- R6: While reset is asserted and after it is released, `low_on` = 00, `high_on` = 00, `vres_trip_hi` = 0 and `amux_sel` = 0000.
- R7: Byte 0xA3 turns on both high-side switches. Its bitwise complement 0x5C turns on both low-side switches.
- R8: A frame holds the serial data bits captured MSB first on serial clock rising edges while `spi_cs_n` is low. A frame with other than exactly 8 such edges leaves every output unchanged. This includes frames with no edges at all.
- R9: Codes other than 0x4, 0x5, 0x6 and 0xA leave every output unchanged.
- R10: All bits of an accepted command change together, on the third system clock rising edge after `spi_cs_n` rises. No output changes at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, asynchronous |
| spi_cs_n | input | 1 | Active-low frame select from host, asynchronous |
| spi_mosi | input | 1 | Serial command data from host, MSB first |
| amux_sel | output | 4 | One-hot analog select, 0000 = high impedance |
| low_on | output | 2 | Low-side switch enables, bit 0 = switch 1 |
| high_on | output | 2 | High-side switch enables, bit 0 = switch 1 |
| vres_trip_hi | output | 1 | Reserve monitor trip level, 1 = higher level |

## Verification
The bench builds the bank with its default two-stage synchronizer. With that depth the command-to-output latency is three system clock edges, so the reference model can be held to that exact cycle. The serial clock runs at eight system clocks per period. This lets 7-bit and 9-bit frames and select-only pulses exercise the length gate and the saturating bit counter. Because the comparison runs on every cycle, any output that changes in two steps, or at the wrong time after a frame, is caught.

// File: rtl/squib_cmd_pkg.sv
package squib_cmd_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 4;
  localparam int FRAME_BITS = CODE_W + DATA_W;

  typedef enum logic [CODE_W-1:0] {
    CMD_AMUX = 4'h4,
    CMD_LOW  = 4'h5,
    CMD_AUX  = 4'h6,
    CMD_HIGH = 4'hA
  } cmd_e;

  localparam logic [DATA_W-1:0] AMUX_HIZ = 4'b0000;
  localparam logic [DATA_W-1:0] AMUX_MR  = 4'b0001;
  localparam logic [DATA_W-1:0] AMUX_AIN = 4'b0010;
  localparam logic [DATA_W-1:0] AMUX_BAT = 4'b0100;
  localparam logic [DATA_W-1:0] AMUX_RES = 4'b1000;
endpackage

// File: rtl/squib_sync.sv
module squib_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RST_VAL;
      else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/squib_frame_rx.sv
module squib_frame_rx
  import squib_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_s,
  input  logic                  cs_n_s,
  input  logic                  mosi_s,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic             sck_q;
  logic             cs_q;
  logic [CNT_W-1:0] cnt;
  logic             sck_rise;

  assign sck_rise = sck_s & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt   <= '0;
      frame <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        frame <= {frame[FRAME_BITS-2:0], mosi_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_valid = cs_n_s & ~cs_q & (cnt == CNT_FULL);

  // R8: the bit counter is cleared whenever the frame select is idle
  a_r8_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (cnt == '0));
endmodule

// File: rtl/squib_ctrl_regs.sv
module squib_ctrl_regs
  import squib_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  input  logic [FRAME_BITS-1:0] frame,
  output logic [DATA_W-1:0]     amux_sel,
  output logic [1:0]            low_on,
  output logic [1:0]            high_on,
  output logic                  vres_trip_hi
);
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] data;
  logic [DATA_W-1:0] amux_next;

  assign code = frame[FRAME_BITS-1 -: CODE_W];
  assign data = frame[DATA_W-1:0];

  always_comb begin
    unique case (data)
      AMUX_MR, AMUX_AIN, AMUX_BAT, AMUX_RES: amux_next = data;
      default:                               amux_next = AMUX_HIZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amux_sel     <= AMUX_HIZ;
      low_on       <= 2'b00;
      high_on      <= 2'b00;
      vres_trip_hi <= 1'b0;
    end else if (frame_valid) begin
      case (code)
        CMD_AMUX: amux_sel     <= amux_next;
        CMD_LOW:  low_on       <= ~data[1:0];
        CMD_HIGH: high_on      <= data[1:0];
        CMD_AUX:  vres_trip_hi <= data[0];
        default:  ;
      endcase
    end
  end

  // R2: the analog select never shows more than one source at once
  a_r2_mux_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amux_sel));

  // R9 and R10: with no accepted frame, no output moves
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ($stable(amux_sel) && $stable(low_on) &&
                      $stable(high_on) && $stable(vres_trip_hi)));

  // R3: low-side enables are the inverse of the written data bits
  a_r3_low_active_low: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && code == CMD_LOW) |=> (low_on == ~$past(frame[1:0])));

  // R4: high-side enables follow the written data bits
  a_r4_high_active_high: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && code == CMD_HIGH) |=> (high_on == $past(frame[1:0])));

  // R5: the trip select follows data bit 0
  a_r5_trip_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && code == CMD_AUX) |=> (vres_trip_hi == $past(frame[0])));
endmodule

// File: rtl/squib_cmd_bank.sv
module squib_cmd_bank
  import squib_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic [DATA_W-1:0] amux_sel,
  output logic [1:0]        low_on,
  output logic [1:0]        high_on,
  output logic              vres_trip_hi
);
  logic [2:0]            pins_s;
  logic                  frame_valid;
  logic [FRAME_BITS-1:0] frame;

  squib_sync #(
    .W(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sck, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );

  squib_frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (pins_s[2]),
    .cs_n_s     (pins_s[1]),
    .mosi_s     (pins_s[0]),
    .frame_valid(frame_valid),
    .frame      (frame)
  );

  squib_ctrl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame       (frame),
    .amux_sel    (amux_sel),
    .low_on      (low_on),
    .high_on     (high_on),
    .vres_trip_hi(vres_trip_hi)
  );
endmodule

// File: tb/tb_squib_cmd_bank.sv
module tb_squib_cmd_bank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic [3:0] amux_sel;
  logic [1:0] low_on;
  logic [1:0] high_on;
  logic vres_trip_hi;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R6";

  logic [3:0] exp_amux = 4'h0;
  logic [1:0] exp_low = 2'b00;
  logic [1:0] exp_high = 2'b00;
  logic       exp_trip = 1'b0;

  squib_cmd_bank dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .amux_sel(amux_sel), .low_on(low_on),
    .high_on(high_on), .vres_trip_hi(vres_trip_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(string req);
    checks++;
    if (amux_sel !== exp_amux || low_on !== exp_low ||
        high_on !== exp_high || vres_trip_hi !== exp_trip) begin
      errors++;
      $display("FAIL %s: amux=%b low=%b high=%b trip=%b expected amux=%b low=%b high=%b trip=%b",
               req, amux_sel, low_on, high_on, vres_trip_hi,
               exp_amux, exp_low, exp_high, exp_trip);
    end
  endtask

  // reference comparison on every cycle (R10: exact cycle, all bits together)
  always @(negedge clk) begin
    if (rst_n && !finished) compare(cur_req);
  end

  task automatic model_apply(logic [7:0] b);
    logic [3:0] d = b[3:0];
    case (b[7:4])
      4'h4: exp_amux = (d == 4'h1 || d == 4'h2 || d == 4'h4 || d == 4'h8) ? d : 4'h0;
      4'h5: exp_low = {~d[1], ~d[0]};
      4'hA: exp_high = d[1:0];
      4'h6: exp_trip = d[0];
      default: ;
    endcase
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(int n, logic [15:0] val);
    logic q[$];
    logic [7:0] b;
    @(negedge clk);
    spi_cs_n = 1'b0;
    wait_n(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = val[i];
      q.push_back(val[i]);
      wait_n(HALF);
      spi_sck = 1'b1;
      wait_n(HALF);
      spi_sck = 1'b0;
    end
    wait_n(HALF);
    spi_cs_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    if (q.size() == 8) begin
      b = '0;
      foreach (q[k]) b = {b[6:0], q[k]};
      model_apply(b);
    end
    wait_n(3);
  endtask

  task automatic send_byte(logic [7:0] b);
    send_bits(8, {8'h00, b});
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    exp_amux = 4'h0; exp_low = 2'b00; exp_high = 2'b00; exp_trip = 1'b0;
    wait_n(3);
    compare("R6");
    rst_n = 1'b1;
    wait_n(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: expired, expected run to complete");
    finish_run();
  end

  initial begin
    cur_req = "R6";
    reset_check();

    cur_req = "R1";
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h44);
    send_byte(8'h48); send_byte(8'h40);

    cur_req = "R2";
    send_byte(8'h41); send_byte(8'h43);
    send_byte(8'h48); send_byte(8'h4F);
    send_byte(8'h44); send_byte(8'h4C);

    cur_req = "R3";
    send_byte(8'h5E); send_byte(8'h5D); send_byte(8'h50);
    send_byte(8'h53); send_byte(8'hFC & 8'h5C | 8'h00); send_byte(8'h57);
    send_byte(8'h5B);

    cur_req = "R4";
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hAC);
    send_byte(8'hA3); send_byte(8'hA0); send_byte(8'hAD);

    cur_req = "R5";
    send_byte(8'h61); send_byte(8'h60); send_byte(8'h6F); send_byte(8'h6E);

    cur_req = "R7";
    send_byte(8'h53); send_byte(8'hA0);
    send_byte(8'hA3); send_byte(8'h5C);

    cur_req = "R8";
    send_bits(7, 16'h0050);
    send_bits(9, 16'h00A0);
    send_bits(0, 16'h0000);
    send_bits(1, 16'h0001);
    send_bits(16, 16'h4153);

    cur_req = "R9";
    send_byte(8'h6F); send_byte(8'h42);
    send_byte(8'h00); send_byte(8'h1F); send_byte(8'h70);
    send_byte(8'hB0); send_byte(8'hFF); send_byte(8'h9C);

    cur_req = "R10";
    send_byte(8'hA0); send_byte(8'hA3); send_byte(8'h53); send_byte(8'h50);

    cur_req = "R6";
    reset_check();
    send_byte(8'h41);

    finish_run();
  end
endmodule